// File: doc/BRIEF.md
# AXI4-Lite Fan-Out Decoder with Local Addressing

This block connects one upstream AXI4-Lite manager port to a row of downstream subordinate ports. The subordinates are elements of a strided array: element i owns a window of ELEM_SIZE bytes that starts at ARR_BASE + i*STRIDE. Writes and reads are decoded independently. Each channel picks at most one child and raises that child's address valid, and nothing else.

Every child is given a narrow local address: the upstream address with the element's own offset subtracted, cut to the width of its window. Write data, byte strobes and protection bits pass through unchanged. Handshake readies and responses come back only from the chosen child.

A decode stage holds the chosen child until its response handshake completes. There is one open write and one open read at a time. An address that falls outside every window is answered by the decoder itself with a decode-error response.

Top module: `axil_localizing_decoder`

## Requirements
- R1: An upstream write address seen while the write path is idle is decoded on the next clock edge. From that cycle on, c_awvalid is high only for the element whose window holds the address, and never for more than one element.
- R2: The read address is decoded the same way, independently of the write path. c_arvalid goes only to the matching element, and to at most one element.
- R3: Element i receives the local address (address - ARR_BASE - i*STRIDE) truncated to clog2(ELEM_SIZE) bits. This applies to both c_awaddr and c_araddr; element i's field sits at bits [i*LOC_AW +: LOC_AW].
- R4: s_wdata, s_wstrb and the write and read protection fields arrive at the children unchanged. c_wvalid is raised only toward the selected element, and only while s_wvalid is high.
- R5: s_bvalid and s_bresp come from the selected element. c_bready is driven only toward that element.
- R6: s_rvalid, s_rdata and s_rresp come from the selected element. c_rready is driven only toward that element.
- R7: A write that hits no window raises no child valid. The decoder accepts its address and data itself and answers with s_bresp = 2'b11.
- R8: A read that hits no window raises no child valid. The decoder answers with s_rresp = 2'b11 and s_rdata = 0.
- R9: Once a write address is accepted, s_awready and every c_awvalid stay low until the B handshake. The selection made at acceptance holds during that time, even if a new upstream address is presented.
- R10: Write data may arrive after the write address has been accepted. The response phase opens only after both have been accepted.
- R11: During reset, every child valid and the upstream s_awready, s_arready, s_bvalid and s_rvalid are low.
- R12: A write to one element and a read from another element proceed in the same cycles, each on its own channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awvalid | input | 1 | Upstream write address valid |
| s_awready | output | 1 | Upstream write address ready |
| s_awaddr | input | ADDR_W | Upstream write address |
| s_awprot | input | 3 | Upstream write protection |
| s_wvalid | input | 1 | Upstream write data valid |
| s_wready | output | 1 | Upstream write data ready |
| s_wdata | input | DATA_W | Upstream write data |
| s_wstrb | input | DATA_W/8 | Upstream byte strobes |
| s_bvalid | output | 1 | Upstream write response valid |
| s_bready | input | 1 | Upstream write response ready |
| s_bresp | output | 2 | Upstream write response code |
| s_arvalid | input | 1 | Upstream read address valid |
| s_arready | output | 1 | Upstream read address ready |
| s_araddr | input | ADDR_W | Upstream read address |
| s_arprot | input | 3 | Upstream read protection |
| s_rvalid | output | 1 | Upstream read data valid |
| s_rready | input | 1 | Upstream read data ready |
| s_rdata | output | DATA_W | Upstream read data |
| s_rresp | output | 2 | Upstream read response code |
| c_awvalid | output | NUM_ELEM | Per-element write address valid |
| c_awready | input | NUM_ELEM | Per-element write address ready |
| c_awaddr | output | NUM_ELEM*LOC_AW | Per-element local write address |
| c_awprot | output | 3 | Write protection to all elements |
| c_wvalid | output | NUM_ELEM | Per-element write data valid |
| c_wready | input | NUM_ELEM | Per-element write data ready |
| c_wdata | output | DATA_W | Write data to all elements |
| c_wstrb | output | DATA_W/8 | Byte strobes to all elements |
| c_bvalid | input | NUM_ELEM | Per-element write response valid |
| c_bready | output | NUM_ELEM | Per-element write response ready |
| c_bresp | input | NUM_ELEM*2 | Per-element write response code |
| c_arvalid | output | NUM_ELEM | Per-element read address valid |
| c_arready | input | NUM_ELEM | Per-element read address ready |
| c_araddr | output | NUM_ELEM*LOC_AW | Per-element local read address |
| c_arprot | output | 3 | Read protection to all elements |
| c_rvalid | input | NUM_ELEM | Per-element read data valid |
| c_rready | output | NUM_ELEM | Per-element read data ready |
| c_rdata | input | NUM_ELEM*DATA_W | Per-element read data |
| c_rresp | input | NUM_ELEM*2 | Per-element read response code |

## Verification
A write aimed at one element and a read aimed at another can share every cycle: both address valids can rise together, and both responses can be presented together. The bench provokes this by raising s_awvalid, s_wvalid and s_arvalid on the same edge, toward elements 1 and 3. It then raises both children's response valids in one cycle. It judges the result by requiring that c_awvalid and c_arvalid are one-hot on different bits in the same cycle. In the response cycle, c_bready and c_rready must point at their own elements and neither response may leak onto the other channel's mux.

// File: rtl/axld_pkg.sv
package axld_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_RESP = 2'd2
    } phase_e;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_DECERR = 2'b11;

endpackage

// File: rtl/axld_match.sv
module axld_match #(
    parameter int          ADDR_W    = 32,
    parameter int          NUM_ELEM  = 4,
    parameter int unsigned ARR_BASE  = 32'h0000_1000,
    parameter int unsigned STRIDE    = 32'h0000_0100,
    parameter int unsigned ELEM_SIZE = 32'h0000_0040
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_ELEM-1:0] hit,
    output logic                miss
);

    for (genvar i = 0; i < NUM_ELEM; i++) begin : g_win
        localparam logic [ADDR_W-1:0] LO = ADDR_W'(ARR_BASE + i * STRIDE);
        logic [ADDR_W-1:0] off;
        assign off    = addr - LO;
        assign hit[i] = (addr >= LO) && (off < ADDR_W'(ELEM_SIZE));
    end

    assign miss = ~|hit;

endmodule

// File: rtl/axld_wr_ctrl.sv
module axld_wr_ctrl
    import axld_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int NUM_ELEM = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    s_awvalid,
    input  logic [ADDR_W-1:0]       s_awaddr,
    input  logic [2:0]              s_awprot,
    output logic                    s_awready,
    input  logic                    s_wvalid,
    output logic                    s_wready,
    output logic                    s_bvalid,
    output logic [1:0]              s_bresp,
    input  logic                    s_bready,
    input  logic [NUM_ELEM-1:0]     hit,
    input  logic                    miss,
    output logic [NUM_ELEM-1:0]     c_awvalid,
    input  logic [NUM_ELEM-1:0]     c_awready,
    output logic [NUM_ELEM-1:0]     c_wvalid,
    input  logic [NUM_ELEM-1:0]     c_wready,
    input  logic [NUM_ELEM-1:0]     c_bvalid,
    input  logic [2*NUM_ELEM-1:0]   c_bresp,
    output logic [NUM_ELEM-1:0]     c_bready,
    output logic [ADDR_W-1:0]       addr_o,
    output logic [2:0]              prot_o
);

    typedef struct packed {
        phase_e              ph;
        logic [NUM_ELEM-1:0] sel;
        logic                miss;
        logic                aw_done;
        logic                w_done;
        logic [ADDR_W-1:0]   addr;
        logic [2:0]          prot;
    } wr_st_t;

    wr_st_t st_d, st_q;

    logic       aw_rdy, w_rdy, bv_sel, aw_fin, w_fin;
    logic [1:0] br_sel;

    always_comb begin
        st_d      = st_q;
        s_awready = 1'b0;
        s_wready  = 1'b0;
        s_bvalid  = 1'b0;
        s_bresp   = RESP_OKAY;
        c_awvalid = '0;
        c_wvalid  = '0;
        c_bready  = '0;
        aw_rdy    = st_q.miss | (|(st_q.sel & c_awready));
        w_rdy     = st_q.miss | (|(st_q.sel & c_wready));
        bv_sel    = |(st_q.sel & c_bvalid);
        br_sel    = '0;
        for (int i = 0; i < NUM_ELEM; i++) begin
            if (st_q.sel[i]) br_sel = br_sel | c_bresp[2*i +: 2];
        end
        aw_fin = 1'b0;
        w_fin  = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (s_awvalid) begin
                    st_d.ph      = PH_ADDR;
                    st_d.sel     = hit;
                    st_d.miss    = miss;
                    st_d.addr    = s_awaddr;
                    st_d.prot    = s_awprot;
                    st_d.aw_done = 1'b0;
                    st_d.w_done  = 1'b0;
                end
            end
            PH_ADDR: begin
                c_awvalid    = st_q.aw_done ? '0 : st_q.sel;
                s_awready    = !st_q.aw_done && aw_rdy;
                c_wvalid     = (st_q.w_done || !s_wvalid) ? '0 : st_q.sel;
                s_wready     = !st_q.w_done && w_rdy;
                aw_fin       = st_q.aw_done || (s_awvalid && !st_q.aw_done && aw_rdy);
                w_fin        = st_q.w_done || (s_wvalid && !st_q.w_done && w_rdy);
                st_d.aw_done = aw_fin;
                st_d.w_done  = w_fin;
                if (aw_fin && w_fin) st_d.ph = PH_RESP;
            end
            PH_RESP: begin
                s_bvalid = st_q.miss ? 1'b1 : bv_sel;
                s_bresp  = st_q.miss ? RESP_DECERR : br_sel;
                c_bready = st_q.miss ? '0 : (st_q.sel & {NUM_ELEM{s_bready}});
                if ((st_q.miss || bv_sel) && s_bready) st_d.ph = PH_IDLE;
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o = st_q.addr;
    assign prot_o = st_q.prot;

    // R1
    aw_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(c_awvalid));

    // R9
    aw_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_awvalid && s_awready) |=> !s_awready);

    // R4
    w_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|c_wvalid) |-> s_wvalid);

    // R7
    wr_decerr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_bvalid && st_q.miss) |-> (s_bresp == RESP_DECERR && c_bready == '0));

endmodule

// File: rtl/axld_rd_ctrl.sv
module axld_rd_ctrl
    import axld_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int NUM_ELEM = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       s_arvalid,
    input  logic [ADDR_W-1:0]          s_araddr,
    input  logic [2:0]                 s_arprot,
    output logic                       s_arready,
    output logic                       s_rvalid,
    output logic [DATA_W-1:0]          s_rdata,
    output logic [1:0]                 s_rresp,
    input  logic                       s_rready,
    input  logic [NUM_ELEM-1:0]        hit,
    input  logic                       miss,
    output logic [NUM_ELEM-1:0]        c_arvalid,
    input  logic [NUM_ELEM-1:0]        c_arready,
    input  logic [NUM_ELEM-1:0]        c_rvalid,
    input  logic [NUM_ELEM*DATA_W-1:0] c_rdata,
    input  logic [2*NUM_ELEM-1:0]      c_rresp,
    output logic [NUM_ELEM-1:0]        c_rready,
    output logic [ADDR_W-1:0]          addr_o,
    output logic [2:0]                 prot_o
);

    typedef struct packed {
        phase_e              ph;
        logic [NUM_ELEM-1:0] sel;
        logic                miss;
        logic [ADDR_W-1:0]   addr;
        logic [2:0]          prot;
    } rd_st_t;

    rd_st_t st_d, st_q;

    logic              ar_rdy, rv_sel;
    logic [1:0]        rr_sel;
    logic [DATA_W-1:0] rd_sel;

    always_comb begin
        st_d      = st_q;
        s_arready = 1'b0;
        s_rvalid  = 1'b0;
        s_rdata   = '0;
        s_rresp   = RESP_OKAY;
        c_arvalid = '0;
        c_rready  = '0;
        ar_rdy    = st_q.miss | (|(st_q.sel & c_arready));
        rv_sel    = |(st_q.sel & c_rvalid);
        rr_sel    = '0;
        rd_sel    = '0;
        for (int i = 0; i < NUM_ELEM; i++) begin
            if (st_q.sel[i]) begin
                rr_sel = rr_sel | c_rresp[2*i +: 2];
                rd_sel = rd_sel | c_rdata[DATA_W*i +: DATA_W];
            end
        end
        unique case (st_q.ph)
            PH_IDLE: begin
                if (s_arvalid) begin
                    st_d.ph   = PH_ADDR;
                    st_d.sel  = hit;
                    st_d.miss = miss;
                    st_d.addr = s_araddr;
                    st_d.prot = s_arprot;
                end
            end
            PH_ADDR: begin
                c_arvalid = st_q.sel;
                s_arready = ar_rdy;
                if (s_arvalid && ar_rdy) st_d.ph = PH_RESP;
            end
            PH_RESP: begin
                s_rvalid = st_q.miss ? 1'b1 : rv_sel;
                s_rresp  = st_q.miss ? RESP_DECERR : rr_sel;
                s_rdata  = st_q.miss ? '0 : rd_sel;
                c_rready = st_q.miss ? '0 : (st_q.sel & {NUM_ELEM{s_rready}});
                if ((st_q.miss || rv_sel) && s_rready) st_d.ph = PH_IDLE;
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o = st_q.addr;
    assign prot_o = st_q.prot;

    // R2
    ar_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(c_arvalid));

    // R8
    rd_decerr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rvalid && st_q.miss) |-> (s_rdata == '0 && s_rresp == RESP_DECERR));

    // R6
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rvalid && !s_rready) |=> s_rvalid);

    // R6
    rd_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|c_rready) |-> s_rready);

endmodule

// File: rtl/axil_localizing_decoder.sv
module axil_localizing_decoder #(
    parameter int          ADDR_W    = 32,
    parameter int          DATA_W    = 32,
    parameter int          NUM_ELEM  = 4,
    parameter int unsigned ARR_BASE  = 32'h0000_1000,
    parameter int unsigned STRIDE    = 32'h0000_0100,
    parameter int unsigned ELEM_SIZE = 32'h0000_0040,
    localparam int         LOC_AW    = $clog2(ELEM_SIZE),
    localparam int         STRB_W    = DATA_W / 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       s_awvalid,
    output logic                       s_awready,
    input  logic [ADDR_W-1:0]          s_awaddr,
    input  logic [2:0]                 s_awprot,
    input  logic                       s_wvalid,
    output logic                       s_wready,
    input  logic [DATA_W-1:0]          s_wdata,
    input  logic [STRB_W-1:0]          s_wstrb,
    output logic                       s_bvalid,
    input  logic                       s_bready,
    output logic [1:0]                 s_bresp,
    input  logic                       s_arvalid,
    output logic                       s_arready,
    input  logic [ADDR_W-1:0]          s_araddr,
    input  logic [2:0]                 s_arprot,
    output logic                       s_rvalid,
    input  logic                       s_rready,
    output logic [DATA_W-1:0]          s_rdata,
    output logic [1:0]                 s_rresp,
    output logic [NUM_ELEM-1:0]        c_awvalid,
    input  logic [NUM_ELEM-1:0]        c_awready,
    output logic [NUM_ELEM*LOC_AW-1:0] c_awaddr,
    output logic [2:0]                 c_awprot,
    output logic [NUM_ELEM-1:0]        c_wvalid,
    input  logic [NUM_ELEM-1:0]        c_wready,
    output logic [DATA_W-1:0]          c_wdata,
    output logic [STRB_W-1:0]          c_wstrb,
    input  logic [NUM_ELEM-1:0]        c_bvalid,
    output logic [NUM_ELEM-1:0]        c_bready,
    input  logic [2*NUM_ELEM-1:0]      c_bresp,
    output logic [NUM_ELEM-1:0]        c_arvalid,
    input  logic [NUM_ELEM-1:0]        c_arready,
    output logic [NUM_ELEM*LOC_AW-1:0] c_araddr,
    output logic [2:0]                 c_arprot,
    input  logic [NUM_ELEM-1:0]        c_rvalid,
    output logic [NUM_ELEM-1:0]        c_rready,
    input  logic [NUM_ELEM*DATA_W-1:0] c_rdata,
    input  logic [2*NUM_ELEM-1:0]      c_rresp
);

    logic [NUM_ELEM-1:0] wr_hit, rd_hit;
    logic                wr_miss, rd_miss;
    logic [ADDR_W-1:0]   wr_addr, rd_addr;

    axld_match #(
        .ADDR_W(ADDR_W), .NUM_ELEM(NUM_ELEM), .ARR_BASE(ARR_BASE),
        .STRIDE(STRIDE), .ELEM_SIZE(ELEM_SIZE)
    ) u_wr_match (
        .addr(s_awaddr), .hit(wr_hit), .miss(wr_miss)
    );

    axld_match #(
        .ADDR_W(ADDR_W), .NUM_ELEM(NUM_ELEM), .ARR_BASE(ARR_BASE),
        .STRIDE(STRIDE), .ELEM_SIZE(ELEM_SIZE)
    ) u_rd_match (
        .addr(s_araddr), .hit(rd_hit), .miss(rd_miss)
    );

    axld_wr_ctrl #(.ADDR_W(ADDR_W), .NUM_ELEM(NUM_ELEM)) u_wr (
        .clk(clk), .rst_n(rst_n),
        .s_awvalid(s_awvalid), .s_awaddr(s_awaddr), .s_awprot(s_awprot),
        .s_awready(s_awready), .s_wvalid(s_wvalid), .s_wready(s_wready),
        .s_bvalid(s_bvalid), .s_bresp(s_bresp), .s_bready(s_bready),
        .hit(wr_hit), .miss(wr_miss),
        .c_awvalid(c_awvalid), .c_awready(c_awready),
        .c_wvalid(c_wvalid), .c_wready(c_wready),
        .c_bvalid(c_bvalid), .c_bresp(c_bresp), .c_bready(c_bready),
        .addr_o(wr_addr), .prot_o(c_awprot)
    );

    axld_rd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_ELEM(NUM_ELEM)) u_rd (
        .clk(clk), .rst_n(rst_n),
        .s_arvalid(s_arvalid), .s_araddr(s_araddr), .s_arprot(s_arprot),
        .s_arready(s_arready), .s_rvalid(s_rvalid), .s_rdata(s_rdata),
        .s_rresp(s_rresp), .s_rready(s_rready),
        .hit(rd_hit), .miss(rd_miss),
        .c_arvalid(c_arvalid), .c_arready(c_arready),
        .c_rvalid(c_rvalid), .c_rdata(c_rdata), .c_rresp(c_rresp),
        .c_rready(c_rready),
        .addr_o(rd_addr), .prot_o(c_arprot)
    );

    // Per-element localization: remove the element's offset, keep window bits
    for (genvar i = 0; i < NUM_ELEM; i++) begin : g_loc
        localparam logic [ADDR_W-1:0] OFS = ADDR_W'(ARR_BASE + i * STRIDE);
        assign c_awaddr[i*LOC_AW +: LOC_AW] = LOC_AW'(wr_addr - OFS);
        assign c_araddr[i*LOC_AW +: LOC_AW] = LOC_AW'(rd_addr - OFS);
    end

    assign c_wdata = s_wdata;
    assign c_wstrb = s_wstrb;

    // R12
    rw_indep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|c_awvalid) && (|c_arvalid)) |-> ($countones(c_awvalid) == 1 && $countones(c_arvalid) == 1));

endmodule

// File: tb/sim_axil_localizing_decoder.sv
module sim_axil_localizing_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int LA = 6;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic           s_awvalid = 0, s_awready;
    logic [31:0]    s_awaddr = 0;
    logic [2:0]     s_awprot = 0;
    logic           s_wvalid = 0, s_wready;
    logic [DW-1:0]  s_wdata = 0;
    logic [3:0]     s_wstrb = 0;
    logic           s_bvalid, s_bready = 0;
    logic [1:0]     s_bresp;
    logic           s_arvalid = 0, s_arready;
    logic [31:0]    s_araddr = 0;
    logic [2:0]     s_arprot = 0;
    logic           s_rvalid, s_rready = 0;
    logic [DW-1:0]  s_rdata;
    logic [1:0]     s_rresp;
    logic [N-1:0]   c_awvalid, c_awready = '1;
    logic [N*LA-1:0] c_awaddr, c_araddr;
    logic [2:0]     c_awprot, c_arprot;
    logic [N-1:0]   c_wvalid, c_wready = '1;
    logic [DW-1:0]  c_wdata;
    logic [3:0]     c_wstrb;
    logic [N-1:0]   c_bvalid = '0, c_bready;
    logic [2*N-1:0] c_bresp = '0;
    logic [N-1:0]   c_arvalid, c_arready = '1;
    logic [N-1:0]   c_rvalid = '0, c_rready;
    logic [N*DW-1:0] c_rdata = '0;
    logic [2*N-1:0] c_rresp = '0;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    axil_localizing_decoder u0 (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [LA-1:0] loc(input logic [31:0] a, input int idx);
        logic [31:0] d;
        d = a - 32'h1000 - 32'h100 * idx;
        return d[LA-1:0];
    endfunction

    function automatic logic [N-1:0] oh(input int idx);
        return (idx < 0) ? '0 : N'(1 << idx);
    endfunction

    task automatic do_write(input logic [31:0] addr, input int idx, input logic [31:0] data,
                            input logic [3:0] strb, input logic [2:0] prot,
                            input logic [1:0] cresp, input bit w_late);
        @(negedge clk);
        s_awvalid = 1; s_awaddr = addr; s_awprot = prot;
        s_wvalid = !w_late; s_wdata = data; s_wstrb = strb;
        @(negedge clk);
        chk("R1 c_awvalid", c_awvalid, oh(idx));
        chk("R4 c_wvalid", c_wvalid, w_late ? '0 : oh(idx));
        chk("R7 s_awready", s_awready, 1);
        if (idx >= 0) begin
            chk("R3 c_awaddr", c_awaddr[idx*LA +: LA], loc(addr, idx));
            chk("R4 c_wdata", c_wdata, data);
            chk("R4 c_wstrb", c_wstrb, strb);
            chk("R4 c_awprot", c_awprot, prot);
        end
        if (w_late) begin
            @(negedge clk);
            s_awvalid = 0; s_wvalid = 1; #1;
            chk("R10 c_awvalid after aw", c_awvalid, 0);
            chk("R10 c_wvalid late", c_wvalid, oh(idx));
            chk("R10 no resp yet", s_bvalid, 0);
        end
        @(negedge clk);
        s_awvalid = 0; s_wvalid = 0;
        chk("R1 c_awvalid closed", c_awvalid, 0);
        if (idx >= 0) begin
            c_bvalid[idx] = 1; c_bresp[idx*2 +: 2] = cresp;
        end
        s_bready = 1; #1;
        chk("R5 s_bvalid", s_bvalid, 1);
        chk("R5 s_bresp", s_bresp, (idx < 0) ? 2'b11 : cresp);
        chk("R5 c_bready", c_bready, oh(idx));
        @(negedge clk);
        c_bvalid = '0; c_bresp = '0; s_bready = 0; #1;
        chk("R5 s_bvalid done", s_bvalid, 0);
    endtask

    task automatic do_read(input logic [31:0] addr, input int idx, input logic [31:0] data,
                           input logic [2:0] prot, input logic [1:0] cresp);
        @(negedge clk);
        s_arvalid = 1; s_araddr = addr; s_arprot = prot;
        @(negedge clk);
        chk("R2 c_arvalid", c_arvalid, oh(idx));
        chk("R8 s_arready", s_arready, 1);
        if (idx >= 0) begin
            chk("R3 c_araddr", c_araddr[idx*LA +: LA], loc(addr, idx));
            chk("R4 c_arprot", c_arprot, prot);
        end
        @(negedge clk);
        s_arvalid = 0;
        chk("R2 c_arvalid closed", c_arvalid, 0);
        if (idx >= 0) begin
            c_rvalid[idx] = 1; c_rdata[idx*DW +: DW] = data; c_rresp[idx*2 +: 2] = cresp;
        end
        s_rready = 1; #1;
        chk("R6 s_rvalid", s_rvalid, 1);
        chk("R6 s_rdata", s_rdata, (idx < 0) ? 32'h0 : data);
        chk("R6 s_rresp", s_rresp, (idx < 0) ? 2'b11 : cresp);
        chk("R6 c_rready", c_rready, oh(idx));
        @(negedge clk);
        c_rvalid = '0; c_rdata = '0; c_rresp = '0; s_rready = 0; #1;
        chk("R6 s_rvalid done", s_rvalid, 0);
    endtask

    // R9: selection held while a new address waits; B comes from original element
    task automatic write_hold();
        @(negedge clk);
        s_awvalid = 1; s_awaddr = 32'h0000_1108; s_wvalid = 1; s_wdata = 32'hA5A5_0001; s_wstrb = 4'hF;
        @(negedge clk);
        chk("R9 first sel", c_awvalid, 4'b0010);
        @(negedge clk);
        s_wvalid = 0; s_awaddr = 32'h0000_1204; #1;
        chk("R9 s_awready held low", s_awready, 0);
        chk("R9 c_awvalid held low", c_awvalid, 0);
        c_bvalid = 4'b0110; c_bresp = 8'b0000_1000; s_bready = 0;
        @(negedge clk);
        chk("R9 still no new aw", c_awvalid, 0);
        s_bready = 1; #1;
        chk("R9 bresp from held sel", s_bresp, 2'b10);
        chk("R9 bready to held sel", c_bready, 4'b0010);
        @(negedge clk);
        s_awvalid = 0; s_bready = 0; c_bvalid = '0; c_bresp = '0; #1;
        chk("R9 idle after B", s_bvalid, 0);
    endtask

    // R12: write to element 1 and read from element 3 in the same cycles
    task automatic concurrent();
        @(negedge clk);
        s_awvalid = 1; s_awaddr = 32'h0000_1110; s_wvalid = 1; s_wdata = 32'h1234_5678; s_wstrb = 4'h3;
        s_arvalid = 1; s_araddr = 32'h0000_1330;
        @(negedge clk);
        chk("R12 c_awvalid", c_awvalid, 4'b0010);
        chk("R12 c_arvalid", c_arvalid, 4'b1000);
        chk("R12 c_araddr", c_araddr[3*LA +: LA], 6'h30);
        @(negedge clk);
        s_awvalid = 0; s_wvalid = 0; s_arvalid = 0;
        c_bvalid[1] = 1; c_bresp[3:2] = 2'b00;
        c_rvalid[3] = 1; c_rdata[3*DW +: DW] = 32'hCAFE_F00D; c_rresp[7:6] = 2'b00;
        s_bready = 1; s_rready = 1; #1;
        chk("R12 s_bvalid", s_bvalid, 1);
        chk("R12 s_rvalid", s_rvalid, 1);
        chk("R12 s_rdata", s_rdata, 32'hCAFE_F00D);
        chk("R12 c_bready", c_bready, 4'b0010);
        chk("R12 c_rready", c_rready, 4'b1000);
        @(negedge clk);
        c_bvalid = '0; c_rvalid = '0; c_rdata = '0; s_bready = 0; s_rready = 0;
    endtask

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        failures++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11
        chk("R11 c_awvalid", c_awvalid, 0);
        chk("R11 c_arvalid", c_arvalid, 0);
        chk("R11 s_awready", s_awready, 0);
        chk("R11 s_arready", s_arready, 0);
        chk("R11 s_bvalid", s_bvalid, 0);
        chk("R11 s_rvalid", s_rvalid, 0);
        rst_n = 1;
        do_write(32'h0000_1004, 0, 32'hDEAD_BEEF, 4'hF, 3'b010, 2'b00, 0);
        do_write(32'h0000_123C, 2, 32'h0BAD_F00D, 4'h5, 3'b101, 2'b10, 0);
        do_write(32'h0000_1320, 3, 32'h5555_AAAA, 4'hC, 3'b001, 2'b00, 1);
        do_write(32'h0000_1040, -1, 32'h1, 4'hF, 3'b000, 2'b00, 0);
        do_write(32'h0000_0FFC, -1, 32'h2, 4'hF, 3'b000, 2'b00, 0);
        do_read(32'h0000_1108, 1, 32'h0102_0304, 3'b110, 2'b00);
        do_read(32'h0000_103F, 0, 32'hFFFF_0000, 3'b011, 2'b10);
        do_read(32'h0000_1400, -1, 32'h0, 3'b000, 2'b00);
        do_read(32'h0000_12C0, -1, 32'h0, 3'b000, 2'b00);
        write_hold();
        concurrent();
        repeat (2) @(negedge clk);
        finish_up();
    end

endmodule